// File: doc/BRIEF.md
# Serial Q15 FIR Filter Engine

This block filters a stream of signed 16-bit fractional samples with a finite impulse response of up to 63 taps. A single multiplier is shared across all taps. Each accepted sample starts one multiply-accumulate pass over the stored history, with one tap per clock. The result is then rounded, clamped and returned as one 16-bit sample with a one-cycle valid strobe.

Coefficients are written one at a time through a plain write port. The number of active taps is a run-time input, and it is captured when a sample is accepted. The sample history sits in a ring buffer whose write position advances by one per sample. A synchronous clear input zeroes that history. A new sample is taken only while the engine is idle, which `in_ready` shows.

Top module: `fir_q15_engine`

## Requirements
- R1: Reset state. After reset `in_ready` is 1, `out_valid` is 0 and every stored past sample is zero, so the first outputs see a zero history.
- R2: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from that edge until the result is presented. Any `in_valid`, `in_sample` or `tap_count` activity in that window has no effect.
- R3: `out_valid` is high for exactly one cycle. It rises after the edge N+1 clock edges past the accepting edge, where N is the effective tap count. `in_ready` is 1 again in that same cycle.
- R4: The output equals (16384 + sum over k<N of coef[k]·x[n−k]) after clamping, arithmetically shifted right by 15, keeping the low 16 bits. Each product is taken at full 32-bit width with both operands sign-extended, so (−32768)·(−32768) = +2^30.
- R5: A clamped sum above 2^30−1 becomes 2^30−1, so the output is 0x7FFF and never wraps to a negative value.
- R6: A clamped sum below −2^30 becomes −2^30, so the output is 0x8000 and never wraps to a positive value.
- R7: Rounding is half-up at the 15-bit shift. With one tap of 16384 (0.5), inputs 1, −1, 3 and −3 give 1, 0, 2 and −1.
- R8: `tap_count` is sampled on the accepting edge. A value of 0 acts as 1 tap.
- R9: A one-cycle pulse on `hist_clr` while the engine is idle zeroes all stored past samples.
- R10: A write with `coef_we` high stores `coef_val` as coefficient `coef_idx`. Coefficient k multiplies the sample k steps older than the newest one. A write to index 63 or above is ignored.
- R11: The history holds the 63 most recent samples. Samples older than that no longer contribute, and this holds across any number of ring wrap-arounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hist_clr | input | 1 | Synchronous clear of the sample history |
| coef_we | input | 1 | Coefficient write enable |
| coef_idx | input | 6 | Coefficient index (tap age) |
| coef_val | input | 16 | Coefficient value, Q15 |
| tap_count | input | 6 | Active tap count, 0 treated as 1 |
| in_valid | input | 1 | Input sample offered |
| in_sample | input | 16 | Input sample, Q15 |
| in_ready | output | 1 | Engine idle, sample can be taken |
| out_valid | output | 1 | One-cycle result strobe |
| out_sample | output | 16 | Filtered sample, Q15 |

## Verification
A result is due N+1 rising edges after the accepting edge: N edges for the multiply-accumulate pass and one edge to register the rounded, clamped value. The bench drives and samples 1 ns after each rising edge. It counts edges from acceptance until `out_valid` appears and compares that count with N+1 before it compares the sample. Busy-window checks are made in the cycle right after acceptance, when `in_ready` must already be low. Every expected sample comes from a model of the history and coefficients kept in the bench with 64-bit arithmetic.

// File: rtl/fir_pkg.sv
package fir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_FIN  = 2'd2
  } fir_state_e;

endpackage

// File: rtl/fir_hist_ring.sv
module fir_hist_ring #(
  parameter int DEPTH = 63,
  parameter int DW    = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_back,
  output logic [DW-1:0]    rd_data
);

  logic [DW-1:0]    mem [DEPTH];
  logic [IDX_W-1:0] wptr_q, wptr_d;
  logic [IDX_W-1:0] newest_q, newest_d;
  logic [IDX_W-1:0] rd_idx;

  // next pointer state
  always_comb begin
    wptr_d   = wptr_q;
    newest_d = newest_q;
    if (clr) begin
      wptr_d   = '0;
      newest_d = '0;
    end else if (wr_en) begin
      newest_d = wptr_q;
      wptr_d   = (wptr_q == IDX_W'(DEPTH - 1)) ? '0 : wptr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      newest_q <= '0;
    end else begin
      wptr_q   <= wptr_d;
      newest_q <= newest_d;
    end
  end

  // storage: cleared by reset and by clr, written at the ring pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wptr_q] <= wr_data;
    end
  end

  // walk backwards from the newest entry, wrapping modulo DEPTH
  always_comb begin
    rd_idx = newest_q - rd_back
           + ((rd_back > newest_q) ? IDX_W'(DEPTH) : '0);
    rd_data = mem[rd_idx];
  end

endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int DEPTH = 63,
  parameter int DW    = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic          wr_ok;

  assign wr_ok = we && ({1'b0, waddr} < (IDX_W + 1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/fir_round_sat.sv
module fir_round_sat #(
  parameter int DW    = 16,
  parameter int ACC_W = 38
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic        [DW-1:0]    q_o
);

  localparam int FRAC = 2 * DW - 2;
  localparam logic signed [ACC_W-1:0] LIM_HI = (ACC_W'(1) << FRAC) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] LIM_LO = -(ACC_W'(1) << FRAC);

  always_comb begin
    if (acc_i > LIM_HI)      q_o = {1'b0, {(DW-1){1'b1}}};
    else if (acc_i < LIM_LO) q_o = {1'b1, {(DW-1){1'b0}}};
    else                     q_o = acc_i[FRAC:DW-1];
  end

endmodule

// File: rtl/fir_q15_engine.sv
module fir_q15_engine #(
  parameter int NTAP_MAX = 63,
  parameter int DW       = 16,
  localparam int IDX_W   = $clog2(NTAP_MAX),
  localparam int CNT_W   = $clog2(NTAP_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hist_clr,
  input  logic             coef_we,
  input  logic [IDX_W-1:0] coef_idx,
  input  logic [DW-1:0]    coef_val,
  input  logic [CNT_W-1:0] tap_count,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_sample,
  output logic             in_ready,
  output logic             out_valid,
  output logic [DW-1:0]    out_sample
);
  import fir_pkg::*;

  localparam int PROD_W = 2 * DW;
  localparam int ACC_W  = PROD_W + $clog2(NTAP_MAX);
  localparam logic signed [ACC_W-1:0] RND    = ACC_W'(1) << (DW - 2);
  localparam logic signed [ACC_W-1:0] LIM_HI = (ACC_W'(1) << (PROD_W - 2)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] LIM_LO = -(ACC_W'(1) << (PROD_W - 2));

  fir_state_e              state_q, state_d;
  logic [CNT_W-1:0]        k_q, k_d;
  logic [CNT_W-1:0]        ntap_q, ntap_d;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic [DW-1:0]           out_q, out_d;
  logic                    outv_q, outv_d;

  logic                     accept;
  logic [DW-1:0]            hist_rd, coef_rd;
  logic signed [PROD_W-1:0] h_ext, c_ext, prod;
  logic [DW-1:0]            sat_q15;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;

  fir_hist_ring #(.DEPTH(NTAP_MAX), .DW(DW)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (hist_clr),
    .wr_en  (accept),
    .wr_data(in_sample),
    .rd_back(IDX_W'(k_q)),
    .rd_data(hist_rd)
  );

  fir_coef_bank #(.DEPTH(NTAP_MAX), .DW(DW)) u_coef (
    .clk  (clk),
    .we   (coef_we),
    .waddr(coef_idx),
    .wdata(coef_val),
    .raddr(IDX_W'(k_q)),
    .rdata(coef_rd)
  );

  // full-width signed product
  assign h_ext = PROD_W'(signed'(hist_rd));
  assign c_ext = PROD_W'(signed'(coef_rd));
  assign prod  = h_ext * c_ext;

  fir_round_sat #(.DW(DW), .ACC_W(ACC_W)) u_rsat (
    .acc_i(acc_q),
    .q_o  (sat_q15)
  );

  always_comb begin
    state_d = state_q;
    k_d     = k_q;
    ntap_d  = ntap_q;
    acc_d   = acc_q;
    out_d   = out_q;
    outv_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          ntap_d  = (tap_count == '0) ? CNT_W'(1) : tap_count;
          k_d     = '0;
          acc_d   = RND;
          state_d = ST_MAC;
        end
      end
      ST_MAC: begin
        acc_d = acc_q + ACC_W'(prod);
        k_d   = k_q + CNT_W'(1);
        if (k_q == ntap_q - CNT_W'(1)) state_d = ST_FIN;
      end
      ST_FIN: begin
        out_d   = sat_q15;
        outv_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      ntap_q  <= CNT_W'(1);
      acc_q   <= '0;
      out_q   <= '0;
      outv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      k_q     <= k_d;
      ntap_q  <= ntap_d;
      acc_q   <= acc_d;
      out_q   <= out_d;
      outv_q  <= outv_d;
    end
  end

  assign out_valid  = outv_q;
  assign out_sample = out_q;

  // R2: engine goes busy right after taking a sample
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R3: single-cycle strobe, ready again with it
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_ready_with_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
  p_tap_index_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MAC) |-> (k_q < ntap_q));

  // R5 / R6: clamped outputs
  p_sat_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN && acc_q > LIM_HI) |=> (out_sample == {1'b0, {(DW-1){1'b1}}}));
  p_sat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN && acc_q < LIM_LO) |=> (out_sample == {1'b1, {(DW-1){1'b0}}}));

  // R8: captured tap count is never zero
  p_taps_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ntap_q != '0));

endmodule

// File: tb/fir_q15_engine_bench.sv
`timescale 1ns/1ps
module fir_q15_engine_bench;

  localparam int NT = 63;

  logic        clk;
  logic        rst_n;
  logic        hist_clr;
  logic        coef_we;
  logic [5:0]  coef_idx;
  logic [15:0] coef_val;
  logic [5:0]  tap_count;
  logic        in_valid;
  logic [15:0] in_sample;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_sample;

  int checks;
  int errors;

  longint          cm [NT];
  logic signed [15:0] mh [NT];
  logic [15:0]     lfsr;

  fir_q15_engine u_fir_q15_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .hist_clr  (hist_clr),
    .coef_we   (coef_we),
    .coef_idx  (coef_idx),
    .coef_val  (coef_val),
    .tap_count (tap_count),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_sample(out_sample)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input int n);
    longint acc;
    acc = 16384;
    for (int k = 0; k < n; k++) acc += cm[k] * longint'(mh[k]);
    if (acc > 64'sd1073741823) acc = 64'sd1073741823;
    if (acc < -64'sd1073741824) acc = -64'sd1073741824;
    acc = acc >>> 15;
    return acc[15:0];
  endfunction

  task automatic wcoef(input int idx, input int val);
    coef_we  = 1'b1;
    coef_idx = 6'(idx);
    coef_val = 16'(val);
    @(posedge clk); #1;
    coef_we  = 1'b0;
    if (idx < NT) cm[idx] = longint'(signed'(16'(val)));
  endtask

  task automatic clear_hist();
    hist_clr = 1'b1;
    @(posedge clk); #1;
    hist_clr = 1'b0;
    for (int i = 0; i < NT; i++) mh[i] = '0;
  endtask

  // offer one sample, optionally disturb the busy window, check latency and value
  task automatic send(input logic [15:0] s, input int t, input bit poke, input string tag);
    int n;
    int lat;
    logic [15:0] exp;
    n = (t == 0) ? 1 : t;
    for (int i = NT - 1; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = signed'(s);
    exp = model(n);
    in_valid  = 1'b1;
    in_sample = s;
    tap_count = 6'(t);
    @(posedge clk); #1;
    in_valid = 1'b0;
    lat = 0;
    if (poke) begin
      in_valid  = 1'b1;
      in_sample = ~s;
      tap_count = 6'(t) ^ 6'h15;
      check(in_ready == 1'b0, "R2 busy ready", longint'(in_ready), 0);
      @(posedge clk); #1;
      in_valid  = 1'b0;
      tap_count = 6'(t);
      lat = 1;
    end
    while (!out_valid && lat < 300) begin
      @(posedge clk); #1;
      lat++;
    end
    check(lat == n + 1, "R3 latency", lat, n + 1);
    check(out_sample == exp, tag, longint'(signed'(out_sample)), longint'(signed'(exp)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; hist_clr = 1'b0; coef_we = 1'b0; coef_idx = '0; coef_val = '0;
    tap_count = '0; in_valid = 1'b0; in_sample = '0;
    lfsr = 16'hACE1;
    for (int i = 0; i < NT; i++) begin cm[i] = 0; mh[i] = '0; end
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: idle after reset
    check(in_ready == 1'b1, "R1 ready", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);

    // R10: load a spread of coefficients
    for (int k = 0; k < NT; k++) wcoef(k, ((k * 1237 + 311) % 4001) - 2000);

    // R1: first output sees zero history
    send(16'd1000, 63, 1'b0, "R1 zero history");

    // R11: impulse response across one full ring plus extra wraps
    send(16'd0, 63, 1'b0, "R11 flush");
    for (int i = 0; i < 70; i++) send((i == 2) ? 16'd20000 : 16'd0, 63, 1'b0, "R11 impulse");

    // R4 / R8: pseudo-random stream, tap counts sweep 0..63
    for (int i = 0; i < 128; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr, i % 64, 1'b0, "R4 random");
    end

    // R2 / R8: disturbances in the busy window have no effect
    for (int i = 0; i < 6; i++) send(16'(i * 3001 - 9000), 5 + i, 1'b1, "R2 busy ignored");
    send(16'h1234, 0, 1'b1, "R8 zero taps");

    // R10: index 63 is outside the bank and must not disturb outputs
    wcoef(63, 16'h7000);
    for (int i = 0; i < 4; i++) send(16'(1000 * i + 17), 63, 1'b0, "R10 ignored write");

    // R9: clear then impulse gives only c[0]-term contributions
    clear_hist();
    send(16'd8000, 63, 1'b0, "R9 cleared");
    send(16'd0, 63, 1'b0, "R9 cleared tail");

    // R5: large positive sum clamps
    for (int k = 0; k < NT; k++) wcoef(k, 32767);
    clear_hist();
    for (int i = 0; i < 8; i++) send(16'd32767, 63, 1'b0, "R5 sat high");
    check(out_sample == 16'h7FFF, "R5 clamp value", longint'(out_sample), 32767);

    // R6: large negative sum clamps
    for (int i = 0; i < 70; i++) send(16'h8000, 63, 1'b0, "R6 sat low");
    check(out_sample == 16'h8000, "R6 clamp value", longint'(out_sample), 32768);

    // R4: -1 * -1 single tap, full-width product then clamp
    wcoef(0, 16'h8000);
    clear_hist();
    send(16'h8000, 1, 1'b0, "R4 minus one squared");
    check(out_sample == 16'h7FFF, "R4 minus one squared value", longint'(out_sample), 32767);

    // R7: round half up with coefficient 0.5
    wcoef(0, 16384);
    send(16'd1, 1, 1'b0, "R7 round +1");
    check(out_sample == 16'd1, "R7 +1", longint'(out_sample), 1);
    send(16'hFFFF, 1, 1'b0, "R7 round -1");
    check(out_sample == 16'd0, "R7 -1", longint'(out_sample), 0);
    send(16'd3, 1, 1'b0, "R7 round +3");
    check(out_sample == 16'd2, "R7 +3", longint'(out_sample), 2);
    send(16'hFFFD, 1, 1'b0, "R7 round -3");
    check(out_sample == 16'hFFFF, "R7 -3", longint'(out_sample), 65535);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule